// File: doc/BRIEF.md
# At-Speed Link Self-Test Result Register

This block runs a bit-error test on six parallel receive lanes at the full system clock rate and collects a two-bit result for each lane in a 12-bit status register. A test-access controller outside the block sends a single-cycle start pulse when it enters its idle-run state with the self-test instruction selected. The block then waits out a fixed alignment allowance, which gives the far-end transmitter time to begin. After that it compares a fixed number of received words on every lane against the expected test pattern. For word index k of the window, the expected pattern is k modulo 2^WORD_W.

Each lane counts its mismatching bits in a counter that saturates at its maximum. When the window closes, the block sets all done flags together and latches one verdict per lane. A lane passes when its error count is at or below a limit, which by default is the window's bit count times 1e-7, rounded down. A capture strobe copies the status into a scan data register, and shift strobes then move it out serially. While a test is in progress, the receive path is held enabled whatever the power-down and receiver-enable inputs say.

Top module: `bist_speed_status`

## Requirements
- R1: After reset the status register, `busy_o` and `tdo_o` are all 0.
- R2: A start pulse clears the whole status register and raises `busy_o` from the next cycle. A start that arrives during a test restarts it.
- R3: The first ALIGN_CYC cycles after start are an alignment allowance, and lane data received during them is ignored.
- R4: In the WINDOW_WORDS cycles that follow, word k of each lane is compared with k mod 2^WORD_W. At the end of that window `busy_o` falls and all done flags rise on the same edge.
- R5: A lane's verdict bit is 1 exactly when its count of mismatched bits over the window is ERR_LIMIT or fewer. ERR_LIMIT defaults to floor(WINDOW_WORDS*WORD_W/1e7).
- R6: Status layout: for lane c (0-based), bit 2c+1 is its done flag and bit 2c is its verdict. Lane 5 therefore sits at the MSB.
- R7: A verdict bit reads 0 whenever the done flag of its lane is 0.
- R8: The per-lane error counter saturates at 2^ERR_W-1 rather than wrapping, so a heavily corrupted lane always fails.
- R9: A capture strobe loads the status into the scan register, and `tdo_o` then shows bit 0. Each shift strobe moves the register one place toward bit 0 and enters `tdi_i` at bit 11. Capture wins over a shift in the same cycle.
- R10: `rx_on_o` is 1 while `busy_o` is 1. Otherwise it equals `rx_en_i & ~pwr_dn_i`.
- R11: Once a test has finished, lane data has no effect on the status until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse from the test controller |
| cap_i | input | 1 | Capture strobe for the scan register |
| shift_i | input | 1 | Shift strobe for the scan register |
| tdi_i | input | 1 | Serial scan input |
| tdo_o | output | 1 | Serial scan output (bit 0 of the scan register) |
| rx_words_i | input | NUM_CH*WORD_W | Received words, lane c at bits [c*WORD_W +: WORD_W] |
| pwr_dn_i | input | 1 | Power-down request, active high |
| rx_en_i | input | 1 | Receiver enable request |
| rx_on_o | output | 1 | Effective receiver enable |
| busy_o | output | 1 | Test in progress (alignment or window) |
| status_o | output | 2*NUM_CH | Result register (done/verdict per lane) |

## Verification
The assertions assume that start is a clean single-cycle pulse and that every input changes only between clock edges. They also assume that the capture and shift strobes follow a finished run, so the scan contents can be predicted. The bench drives all inputs on the falling edge, pulses start for one cycle only, and issues capture and shift only after `busy_o` has fallen. On purpose, it feeds all-ones words during alignment and mismatching words after the window. This exercises the ignore requirements while still respecting those assumptions.

// File: rtl/bist_at_pkg.sv
package bist_at_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ALIGN = 2'd1,
      SEQ_RUN   = 2'd2,
      SEQ_DONE  = 2'd3
   } seq_state_t;

   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/bist_seq.sv
module bist_seq
   import bist_at_pkg::*;
#(
   parameter int ALIGN_CYC    = 4096,
   parameter int WINDOW_WORDS = 2097152,
   parameter int WORD_W       = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              busy_o,
   output logic              run_o,
   output logic              done_o,
   output logic [WORD_W-1:0] exp_word_o
);
   localparam int AL_W  = cnt_width(ALIGN_CYC);
   localparam int WIN_W = cnt_width(WINDOW_WORDS);

   seq_state_t       state_q;
   logic [AL_W-1:0]  al_cnt_q;
   logic [WIN_W-1:0] win_cnt_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         al_cnt_q  <= '0;
         win_cnt_q <= '0;
         done_q    <= 1'b0;
      end else if (start_i) begin
         state_q   <= SEQ_ALIGN;
         al_cnt_q  <= '0;
         win_cnt_q <= '0;
         done_q    <= 1'b0;
      end else begin
         case (state_q)
            SEQ_ALIGN: begin
               if (al_cnt_q == AL_W'(ALIGN_CYC - 1)) state_q <= SEQ_RUN;
               else al_cnt_q <= al_cnt_q + 1'b1;
            end
            SEQ_RUN: begin
               if (win_cnt_q == WIN_W'(WINDOW_WORDS - 1)) begin
                  state_q <= SEQ_DONE;
                  done_q  <= 1'b1;
               end else begin
                  win_cnt_q <= win_cnt_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign busy_o     = (state_q == SEQ_ALIGN) || (state_q == SEQ_RUN);
   assign run_o      = (state_q == SEQ_RUN);
   assign done_o     = done_q;
   assign exp_word_o = WORD_W'(win_cnt_q);
endmodule

// File: rtl/bist_lane_chk.sv
module bist_lane_chk #(
   parameter int WORD_W    = 10,
   parameter int ERR_W     = 25,
   parameter int ERR_LIMIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              en_i,
   input  logic [WORD_W-1:0] rx_word_i,
   input  logic [WORD_W-1:0] exp_word_i,
   output logic              pass_o
);
   localparam int PC_W  = $clog2(WORD_W + 1);
   localparam int SUM_W = ((ERR_W > PC_W) ? ERR_W : PC_W) + 1;
   localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

   logic [WORD_W-1:0] diff;
   logic [PC_W-1:0]   pop;
   logic [SUM_W-1:0]  sum;
   logic [ERR_W-1:0]  cnt_q;
   logic [ERR_W-1:0]  cnt_nxt;

   assign diff = rx_word_i ^ exp_word_i;

   always_comb begin
      pop = '0;
      for (int i = 0; i < WORD_W; i++) pop = pop + PC_W'(diff[i]);
   end

   always_comb begin
      sum = SUM_W'(cnt_q) + SUM_W'(pop);
      if (sum > SUM_W'(CNT_MAX)) cnt_nxt = CNT_MAX;
      else                       cnt_nxt = sum[ERR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else if (en_i)    cnt_q <= cnt_nxt;
   end

   assign pass_o = (cnt_q <= ERR_W'(ERR_LIMIT));
endmodule

// File: rtl/bist_scan_dr.sv
module bist_scan_dr #(
   parameter int LEN = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cap_i,
   input  logic           shift_i,
   input  logic           tdi_i,
   input  logic [LEN-1:0] par_i,
   output logic           tdo_o
);
   logic [LEN-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_q <= '0;
      else if (cap_i)   sr_q <= par_i;
      else if (shift_i) sr_q <= {tdi_i, sr_q[LEN-1:1]};
   end

   assign tdo_o = sr_q[0];
endmodule

// File: rtl/bist_speed_status.sv
module bist_speed_status #(
   parameter int NUM_CH       = 6,
   parameter int WORD_W       = 10,
   parameter int ALIGN_CYC    = 4096,
   parameter int WINDOW_WORDS = 2097152,
   parameter int ERR_LIMIT    = (WINDOW_WORDS * WORD_W) / 10000000,
   parameter int ERR_W        = $clog2(WINDOW_WORDS * WORD_W + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     cap_i,
   input  logic                     shift_i,
   input  logic                     tdi_i,
   output logic                     tdo_o,
   input  logic [NUM_CH*WORD_W-1:0] rx_words_i,
   input  logic                     pwr_dn_i,
   input  logic                     rx_en_i,
   output logic                     rx_on_o,
   output logic                     busy_o,
   output logic [2*NUM_CH-1:0]      status_o
);
   localparam int ST_W = 2 * NUM_CH;

   initial begin
      assert (NUM_CH >= 1)       else $error("NUM_CH must be at least 1");
      assert (WORD_W >= 1)       else $error("WORD_W must be at least 1");
      assert (ALIGN_CYC >= 1)    else $error("ALIGN_CYC must be at least 1");
      assert (WINDOW_WORDS >= 2) else $error("WINDOW_WORDS must be at least 2");
      assert (ERR_W < 31 && ERR_LIMIT < (2 ** ERR_W) - 1)
         else $error("ERR_W too narrow for ERR_LIMIT");
   end

   logic              run;
   logic              done;
   logic [WORD_W-1:0] exp_word;
   logic [NUM_CH-1:0] lane_pass;

   bist_seq #(
      .ALIGN_CYC    (ALIGN_CYC),
      .WINDOW_WORDS (WINDOW_WORDS),
      .WORD_W       (WORD_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .busy_o     (busy_o),
      .run_o      (run),
      .done_o     (done),
      .exp_word_o (exp_word)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      bist_lane_chk #(
         .WORD_W    (WORD_W),
         .ERR_W     (ERR_W),
         .ERR_LIMIT (ERR_LIMIT)
      ) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .clear_i    (start_i),
         .en_i       (run),
         .rx_word_i  (rx_words_i[c*WORD_W +: WORD_W]),
         .exp_word_i (exp_word),
         .pass_o     (lane_pass[c])
      );
      assign status_o[2*c+1] = done;
      assign status_o[2*c]   = done & lane_pass[c];
   end

   bist_scan_dr #(
      .LEN (ST_W)
   ) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (cap_i),
      .shift_i (shift_i),
      .tdi_i   (tdi_i),
      .par_i   (status_o),
      .tdo_o   (tdo_o)
   );

   assign rx_on_o = busy_o | (rx_en_i & ~pwr_dn_i);
endmodule

// File: rtl/bist_speed_status_chk.sv
module bist_speed_status_chk #(
   parameter int NUM_CH = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic                cap_i,
   input logic                busy_o,
   input logic                rx_on_o,
   input logic                tdo_o,
   input logic [2*NUM_CH-1:0] status_o
);
   logic [NUM_CH-1:0] done_bits;

   always_comb begin
      for (int c = 0; c < NUM_CH; c++) done_bits[c] = status_o[2*c+1];
   end

   // R2
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (status_o == '0));

   // R4
   done_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(done_bits) == 0) || ($countones(done_bits) == NUM_CH));

   // R4
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (done_bits == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_vld
      // R7
      verdict_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !status_o[2*c+1] |-> !status_o[2*c]);
   end

   // R9
   capture_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> (tdo_o == $past(status_o[0])));

   // R10
   rx_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> rx_on_o);

   // R11
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(status_o));
endmodule

bind bist_speed_status bist_speed_status_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .cap_i    (cap_i),
   .busy_o   (busy_o),
   .rx_on_o  (rx_on_o),
   .tdo_o    (tdo_o),
   .status_o (status_o)
);

// File: tb/bist_speed_status_test.sv
module bist_speed_status_test;
   localparam int NUM_CH = 6;
   localparam int WORD_W = 10;
   localparam int ALIGN  = 8;
   localparam int WIN    = 64;
   localparam int LIMIT  = 3;
   localparam int EW     = 4;
   localparam int ST_W   = 2 * NUM_CH;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, cap = 1'b0, shift = 1'b0, tdi = 1'b0;
   logic pwr_dn = 1'b0, rx_en = 1'b0;
   logic [NUM_CH*WORD_W-1:0] rx_words = '0;
   logic tdo, rx_on, busy;
   logic [ST_W-1:0] status;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;
   logic [ST_W-1:0] last_exp;

   always #10 clk = ~clk;

   bist_speed_status #(
      .NUM_CH(NUM_CH), .WORD_W(WORD_W), .ALIGN_CYC(ALIGN),
      .WINDOW_WORDS(WIN), .ERR_LIMIT(LIMIT), .ERR_W(EW)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cap_i(cap),
      .shift_i(shift), .tdi_i(tdi), .tdo_o(tdo), .rx_words_i(rx_words),
      .pwr_dn_i(pwr_dn), .rx_en_i(rx_en), .rx_on_o(rx_on),
      .busy_o(busy), .status_o(status)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // full=1: every bit of every window word wrong (R8)
   task automatic do_run(input int r, input bit full);
      int e[NUM_CH];
      logic [ST_W-1:0] exp_st;
      for (int ch = 0; ch < NUM_CH; ch++) e[ch] = (ch + r) % 7;
      @(negedge clk) start = 1'b1; rx_words = '1;
      @(negedge clk) start = 1'b0;
      chk("R2 status cleared", 32'(status), 32'h0);
      chk("R2 busy raised", 32'(busy), 32'h1);
      if (r == 0) begin
         pwr_dn = 1'b1; rx_en = 1'b0;
         #1 chk("R10 forced on while busy", 32'(rx_on), 32'h1);
      end
      repeat (ALIGN) @(negedge clk);  // R3: all-ones words during alignment
      for (int k = 0; k < WIN; k++) begin
         for (int ch = 0; ch < NUM_CH; ch++) begin
            logic [WORD_W-1:0] w;
            w = WORD_W'(k);
            if (full) w = ~w;
            else if (k < e[ch]) w = w ^ (WORD_W'(1) << (k % WORD_W));
            rx_words[ch*WORD_W +: WORD_W] = w;
         end
         if (k == WIN - 1) chk("R4 busy in last word", 32'(busy), 32'h1);
         @(negedge clk);
      end
      chk("R4 busy fallen", 32'(busy), 32'h0);
      for (int ch = 0; ch < NUM_CH; ch++) begin
         exp_st[2*ch+1] = 1'b1;
         exp_st[2*ch]   = full ? 1'b0 : (e[ch] <= LIMIT);
      end
      chk(full ? "R8 saturated fail" : "R3 R5 R6 status", 32'(status), 32'(exp_st));
      rx_words = {NUM_CH{10'h155}};
      repeat (5) @(negedge clk);
      chk("R11 status held", 32'(status), 32'(exp_st));
      last_exp = exp_st;
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 20000 && !finished) begin
         @(posedge clk);
         cyc++;
      end
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog actual=%0d expected=<20000", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [ST_W-1:0] pat;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status", 32'(status), 32'h0);
      chk("R1 busy", 32'(busy), 32'h0);
      chk("R1 tdo", 32'(tdo), 32'h0);

      for (int m = 0; m < 4; m++) begin
         pwr_dn = m[0]; rx_en = m[1];
         #1 chk("R10 idle rx_on", 32'(rx_on), 32'(m[1] & ~m[0]));
      end

      for (int r = 0; r < 7; r++) do_run(r, 1'b0);

      // R9 capture then shift out LSB first
      @(negedge clk) cap = 1'b1;
      @(negedge clk) cap = 1'b0;
      pat = 12'hA5C;
      for (int i = 0; i < ST_W; i++) begin
         chk("R9 shift out", 32'(tdo), 32'(last_exp[i]));
         shift = 1'b1; tdi = pat[i];
         @(negedge clk);
      end
      for (int i = 0; i < ST_W; i++) begin
         chk("R9 tdi through", 32'(tdo), 32'(pat[i]));
         tdi = 1'b0;
         @(negedge clk);
      end
      shift = 1'b0;

      // R9 capture wins over shift
      @(negedge clk) cap = 1'b1; shift = 1'b1;
      @(negedge clk) cap = 1'b0; shift = 1'b0;
      chk("R9 capture priority", 32'(tdo), 32'(last_exp[0]));

      do_run(0, 1'b1);

      // R2 restart during window
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (ALIGN + 5) @(negedge clk);
      rx_words = '1;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R2 restart busy", 32'(busy), 32'h1);
      repeat (ALIGN) @(negedge clk);
      for (int k = 0; k < WIN; k++) begin
         rx_words = {NUM_CH{WORD_W'(k)}};
         @(negedge clk);
      end
      chk("R2 restart all pass", 32'(status), {20'h0, {NUM_CH{2'b11}}});

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule